// File: doc/BRIEF.md
# Stack Frame Save/Restore Sequencer

This block runs the register spill and refill work of a function prologue or epilogue as one multi-cycle operation. A single request supplies four things: a 12-entry register-selection mask, a 5-bit frame-size value and a starting stack pointer, plus, for restore only, a jump-register number. The sequencer then walks the selected registers one at a time. It moves each one between the register file and memory over a simple request/ready port, and it adjusts the stack pointer as it goes.

There are two modes. A save pushes the selected registers with a pre-decrement and then reserves local space. A restore first releases the local space, then pops the selected registers and can report a return target read from a chosen register. A one-cycle done pulse marks the end of the operation. At that point the final stack pointer and the jump target are valid at the outputs.

Top module: `frame_seq`

## Requirements
- R1: The mask is `{listHi, listLo}`, so `listHi` is mask bit 11. Mask bit i selects register 20+i, and restores write only register numbers 20 to 31.
- R2: In save mode the selected registers are visited in ascending register number. For each one the pointer is decremented by 4 and the register is written to the word at the new pointer. Lower-numbered registers therefore land at higher addresses.
- R3: After the last store in save mode, the stack pointer is reduced by `frameImm` times 4, and that value appears on `spOut` when `done` is high.
- R4: Restore mode first adds `frameImm` times 4 to the stack pointer. It then visits the selected registers in descending register number, loading each from the word at the pointer and incrementing the pointer by 4 after each load.
- R5: In restore mode with a nonzero `jumpReg`, `jumpValid` is high at `done` and `jumpTarget` equals that register's value after all loads. When `jumpReg` is zero, `jumpValid` is low.
- R6: With an empty mask no memory request is issued, and only the frame-size adjustment of the stack pointer is made.
- R7: While `memReq` is high and `memReady` is low, the request is held with unchanged address and direction.
- R8: `done` is a single-cycle pulse, raised after the final stack-pointer update. `busy` is low in the cycle after it.
- R9: A `start` raised while an operation is in progress is ignored.
- R10: After reset, `busy`, `done`, `memReq` and `rfWrEn` are low and `spOut` is zero. No memory request or register write occurs while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| restoreMode | input | 1 | 1 = restore, 0 = save |
| listHi | input | 1 | Mask bit 11 |
| listLo | input | 11 | Mask bits 10..0 |
| frameImm | input | 5 | Local frame size in words |
| jumpReg | input | 5 | Register supplying the return target (restore; 0 = none) |
| spIn | input | 32 | Starting stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| spOut | output | 32 | Current/final stack pointer |
| jumpValid | output | 1 | Jump target produced by the last operation |
| jumpTarget | output | 32 | Return target value |
| memReq | output | 1 | Memory request |
| memWrite | output | 1 | Request is a write |
| memAddr | output | 32 | Byte address of the word |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memReady |
| memReady | input | 1 | Memory accepts/completes the request |
| rfRdAddr | output | 5 | Register-file read address |
| rfRdData | input | 32 | Register-file read data (combinational) |
| rfWrEn | output | 1 | Register-file write enable |
| rfWrAddr | output | 5 | Register-file write address |
| rfWrData | output | 32 | Register-file write data |

## Verification
Save runs use several masks, and each one separates a different kind of fault:
- a single low register,
- only the high bit from `listHi`, which catches a misplaced concatenation,
- the full mask, which catches ordering and address faults.

Restore runs use sparse and full masks, with the jump register chosen either among the just-restored registers or outside them. This tells a jump read taken after the loads apart from one taken before them. Empty masks in both modes, memory stalls, and a second start issued during a run separate the pointer-adjust path, the request-hold logic and the start-gating logic.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_XFER,
    ST_POST,
    ST_JUMP,
    ST_FIN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new request
    logic preAdj;   // release local space (restore)
    logic postAdj;  // reserve local space (save)
    logic step;     // one word moved: clear mask bit, move pointer
    logic capJump;  // capture jump target from register file
    logic selJump;  // point register read port at the jump register
  } dpStrobe_t;

endpackage

// File: rtl/frame_seq_pick.sv
// Priority pick over the remaining mask; HIGH_FIRST picks the variant.
module frame_seq_pick #(
  parameter int NUM_REGS   = 12,
  parameter bit HIGH_FIRST = 1'b0,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] mask,
  output logic [IDX_W-1:0]    idx
);

  generate
    if (HIGH_FIRST) begin : g_high
      always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
          if (mask[i]) idx = IDX_W'(i);
        end
      end
    end else begin : g_low
      always_comb begin
        idx = '0;
        for (int i = NUM_REGS - 1; i >= 0; i--) begin
          if (mask[i]) idx = IDX_W'(i);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
  import frame_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       restoreReq,
  input  logic       memReady,
  input  logic       maskEmpty,
  input  logic       modeRestore,
  input  logic       jumpNonZero,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       done,
  output logic       memReq,
  output logic       memWrite,
  output logic       rfWrEn
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    memReq    = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = restoreReq ? ST_PRE : ST_XFER;
        end
      end
      ST_PRE: begin
        strobe.preAdj = 1'b1;
        nextState     = ST_XFER;
      end
      ST_XFER: begin
        if (maskEmpty) begin
          if (!modeRestore)     nextState = ST_POST;
          else if (jumpNonZero) nextState = ST_JUMP;
          else                  nextState = ST_FIN;
        end else begin
          memReq      = 1'b1;
          strobe.step = memReady;
        end
      end
      ST_POST: begin
        strobe.postAdj = 1'b1;
        nextState      = ST_FIN;
      end
      ST_JUMP: begin
        strobe.selJump = 1'b1;
        strobe.capJump = 1'b1;
        nextState      = ST_FIN;
      end
      ST_FIN: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign memWrite = memReq && !modeRestore;
  assign rfWrEn   = memReq && memReady && modeRestore;

endmodule

// File: rtl/frame_seq_dp.sv
module frame_seq_dp
  import frame_seq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 12,
  parameter int BASE_REG = 20,
  parameter int IMM_W    = 5,
  parameter int RA_W     = 5,
  localparam int IDX_W      = $clog2(NUM_REGS),
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int SHIFT      = $clog2(WORD_BYTES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                restoreReq,
  input  logic                listHi,
  input  logic [NUM_REGS-2:0] listLo,
  input  logic [IMM_W-1:0]    frameImm,
  input  logic [RA_W-1:0]     jumpReg,
  input  logic [DATA_W-1:0]   spIn,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic [DATA_W-1:0]   rfRdData,
  output logic                maskEmpty,
  output logic                modeRestore,
  output logic                jumpNonZero,
  output logic [DATA_W-1:0]   spOut,
  output logic                jumpValid,
  output logic [DATA_W-1:0]   jumpTarget,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [RA_W-1:0]     rfRdAddr,
  output logic [RA_W-1:0]     rfWrAddr,
  output logic [DATA_W-1:0]   rfWrData
);

  logic [DATA_W-1:0]   spReg;
  logic [NUM_REGS-1:0] remMask;
  logic [IMM_W-1:0]    immReg;
  logic [RA_W-1:0]     jumpSel;
  logic [IDX_W-1:0]    lowIdx, highIdx, pickIdx;
  logic [DATA_W-1:0]   frameBytes;
  logic [RA_W-1:0]     pickReg;

  frame_seq_pick #(.NUM_REGS(NUM_REGS), .HIGH_FIRST(1'b0)) pickLow_i (
    .mask(remMask), .idx(lowIdx)
  );
  frame_seq_pick #(.NUM_REGS(NUM_REGS), .HIGH_FIRST(1'b1)) pickHigh_i (
    .mask(remMask), .idx(highIdx)
  );

  assign pickIdx    = modeRestore ? highIdx : lowIdx;
  assign pickReg    = RA_W'(BASE_REG) + RA_W'(pickIdx);
  assign frameBytes = DATA_W'(immReg) << SHIFT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spReg       <= '0;
      remMask     <= '0;
      modeRestore <= 1'b0;
      immReg      <= '0;
      jumpSel     <= '0;
      jumpTarget  <= '0;
      jumpValid   <= 1'b0;
    end else begin
      if (strobe.load) begin
        spReg       <= spIn;
        remMask     <= {listHi, listLo};
        modeRestore <= restoreReq;
        immReg      <= frameImm;
        jumpSel     <= jumpReg;
        jumpValid   <= 1'b0;
      end
      if (strobe.preAdj)  spReg <= spReg + frameBytes;
      if (strobe.postAdj) spReg <= spReg - frameBytes;
      if (strobe.step) begin
        remMask <= remMask & ~(NUM_REGS'(1) << pickIdx);
        spReg   <= modeRestore ? spReg + DATA_W'(WORD_BYTES)
                               : spReg - DATA_W'(WORD_BYTES);
      end
      if (strobe.capJump) begin
        jumpTarget <= rfRdData;
        jumpValid  <= 1'b1;
      end
    end
  end

  assign maskEmpty   = (remMask == '0);
  assign jumpNonZero = (jumpSel != '0);
  assign spOut       = spReg;
  assign memAddr     = modeRestore ? spReg : spReg - DATA_W'(WORD_BYTES);
  assign memWdata    = rfRdData;
  assign rfRdAddr    = strobe.selJump ? jumpSel : pickReg;
  assign rfWrAddr    = pickReg;
  assign rfWrData    = memRdata;

endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 12,
  parameter int BASE_REG = 20,
  parameter int IMM_W    = 5,
  parameter int RA_W     = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                restoreMode,
  input  logic                listHi,
  input  logic [NUM_REGS-2:0] listLo,
  input  logic [IMM_W-1:0]    frameImm,
  input  logic [RA_W-1:0]     jumpReg,
  input  logic [DATA_W-1:0]   spIn,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   spOut,
  output logic                jumpValid,
  output logic [DATA_W-1:0]   jumpTarget,
  output logic                memReq,
  output logic                memWrite,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic                memReady,
  output logic [RA_W-1:0]     rfRdAddr,
  input  logic [DATA_W-1:0]   rfRdData,
  output logic                rfWrEn,
  output logic [RA_W-1:0]     rfWrAddr,
  output logic [DATA_W-1:0]   rfWrData
);

  dpStrobe_t strobe;
  logic      maskEmpty, modeRestore, jumpNonZero;

  frame_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .restoreReq(restoreMode),
    .memReady(memReady), .maskEmpty(maskEmpty), .modeRestore(modeRestore),
    .jumpNonZero(jumpNonZero), .strobe(strobe), .busy(busy), .done(done),
    .memReq(memReq), .memWrite(memWrite), .rfWrEn(rfWrEn)
  );

  frame_seq_dp #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BASE_REG(BASE_REG),
    .IMM_W(IMM_W), .RA_W(RA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .restoreReq(restoreMode),
    .listHi(listHi), .listLo(listLo), .frameImm(frameImm), .jumpReg(jumpReg),
    .spIn(spIn), .memRdata(memRdata), .rfRdData(rfRdData),
    .maskEmpty(maskEmpty), .modeRestore(modeRestore), .jumpNonZero(jumpNonZero),
    .spOut(spOut), .jumpValid(jumpValid), .jumpTarget(jumpTarget),
    .memAddr(memAddr), .memWdata(memWdata), .rfRdAddr(rfRdAddr),
    .rfWrAddr(rfWrAddr), .rfWrData(rfWrData)
  );

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 12,
  parameter int BASE_REG = 20,
  parameter int RA_W     = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] spOut,
  input logic              memReq,
  input logic              memWrite,
  input logic              memReady,
  input logic [DATA_W-1:0] memAddr,
  input logic              rfWrEn,
  input logic [RA_W-1:0]   rfWrAddr
);

  localparam int WORD_BYTES = DATA_W / 8;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWrite));

  assert_save_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memReady && memWrite |=> spOut == $past(spOut) - DATA_W'(WORD_BYTES));

  assert_load_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memReady && !memWrite |=> spOut == $past(spOut) + DATA_W'(WORD_BYTES));

  assert_wr_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (32'(rfWrAddr) >= BASE_REG) && (32'(rfWrAddr) < BASE_REG + NUM_REGS)
               && memReq && !memWrite);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !rfWrEn && !done);

endmodule

bind frame_seq frame_seq_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BASE_REG(BASE_REG), .RA_W(RA_W)
) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .spOut(spOut),
  .memReq(memReq), .memWrite(memWrite), .memReady(memReady), .memAddr(memAddr),
  .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr)
);

// File: tb/frame_seq_tb_top.sv
module frame_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, restoreMode = 1'b0, listHi = 1'b0;
  logic [10:0] listLo = '0;
  logic [4:0]  frameImm = '0, jumpReg = '0;
  logic [31:0] spIn = '0;
  logic        busy, done, jumpValid, memReq, memWrite, rfWrEn;
  logic [31:0] spOut, jumpTarget, memAddr, memWdata, memRdata, rfRdData, rfWrData;
  logic [4:0]  rfRdAddr, rfWrAddr;
  logic        memReady = 1'b1;
  logic        stallEn = 1'b0;

  logic [31:0] mem [256];
  logic [31:0] rf  [32];
  int          hsCount = 0;
  int          checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  frame_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .restoreMode(restoreMode),
    .listHi(listHi), .listLo(listLo), .frameImm(frameImm), .jumpReg(jumpReg),
    .spIn(spIn), .busy(busy), .done(done), .spOut(spOut), .jumpValid(jumpValid),
    .jumpTarget(jumpTarget), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady), .rfRdAddr(rfRdAddr), .rfRdData(rfRdData),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData)
  );

  assign memRdata = mem[memAddr[9:2]];
  assign rfRdData = rf[rfRdAddr];

  always @(posedge clk) begin
    if (memReq && memReady) begin
      hsCount <= hsCount + 1;
      if (memWrite) mem[memAddr[9:2]] <= memWdata;
    end
    if (rfWrEn) rf[rfWrAddr] <= rfWrData;
  end

  always @(negedge clk) memReady <= stallEn ? ~memReady : 1'b1;

  typedef struct packed {
    logic        restore;
    logic        hi;
    logic [10:0] lo;
    logic [4:0]  imm;
    logic [4:0]  jr;
    logic [31:0] sp;
    logic        stall;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 11'h001, 5'd0,  5'd0,  32'h200, 1'b0},
    '{1'b0, 1'b1, 11'h7FF, 5'd5,  5'd0,  32'h300, 1'b1},
    '{1'b0, 1'b1, 11'h000, 5'd31, 5'd0,  32'h200, 1'b0},
    '{1'b1, 1'b0, 11'h505, 5'd2,  5'd0,  32'h080, 1'b0},
    '{1'b1, 1'b1, 11'h7FF, 5'd7,  5'd31, 32'h100, 1'b1},
    '{1'b1, 1'b0, 11'h003, 5'd0,  5'd5,  32'h040, 1'b0},
    '{1'b0, 1'b0, 11'h000, 5'd3,  5'd0,  32'h200, 1'b0},
    '{1'b1, 1'b0, 11'h000, 5'd4,  5'd0,  32'h200, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic presetRf();
    for (int r = 0; r < 32; r++) rf[r] = {8'h5A, 8'(r), 16'h0F00 + 16'(r)};
  endtask

  // run one operation; interfere raises a second start mid-run (R9)
  task automatic runOp(input vec_t v, input bit interfere, output bit finished,
                       output int reqs);
    int n = 0;
    int hs0;
    @(negedge clk);
    stallEn = v.stall; restoreMode = v.restore; listHi = v.hi; listLo = v.lo;
    frameImm = v.imm; jumpReg = v.jr; spIn = v.sp; start = 1'b1;
    hs0 = hsCount;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 500) begin
      if (interfere && n == 3) begin
        start = 1'b1; spIn = 32'h0; restoreMode = ~v.restore;
        listHi = 1'b0; listLo = 11'h0; frameImm = 5'd9;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    finished = done;
    reqs = hsCount - hs0;
  endtask

  task automatic doVector(input vec_t v, input bit interfere);
    logic [11:0] m;
    logic [31:0] expRf [32];
    logic [31:0] expSp, base;
    logic [31:0] expMem [256];
    int k, reqs;
    bit fin;
    m = {v.hi, v.lo};
    presetRf();
    for (int a = 0; a < 256; a++) mem[a] = 32'hEEEE_0000 + 32'(a);
    for (int r = 0; r < 32; r++) expRf[r] = rf[r];
    for (int a = 0; a < 256; a++) expMem[a] = mem[a];
    k = 0;
    if (!v.restore) begin
      for (int i = 0; i < 12; i++) if (m[i]) begin
        k++;
        expMem[8'((v.sp - 32'(4 * k)) >> 2)] = rf[20 + i];
      end
      expSp = v.sp - 32'(4 * k) - (32'(v.imm) << 2);
    end else begin
      base = v.sp + (32'(v.imm) << 2);
      for (int i = 11; i >= 0; i--) if (m[i]) begin
        mem[8'((base + 32'(4 * k)) >> 2)] = 32'hC0DE_0000 | 32'(i);
        expRf[20 + i] = 32'hC0DE_0000 | 32'(i);
        k++;
      end
      expSp = base + 32'(4 * k);
    end
    runOp(v, interfere, fin, reqs);
    check(fin, "R8 done reached", 32'(fin), 32'd1);
    check(spOut == expSp, v.restore ? "R4 final sp" : "R3 final sp", spOut, expSp);
    check(reqs == k, m == 0 ? "R6 request count" : "R2/R4 request count",
          32'(reqs), 32'(k));
    if (!v.restore) begin
      for (int a = 0; a < 256; a++)
        if (mem[a] != expMem[a]) check(0, "R2 stored image", mem[a], expMem[a]);
      check(1, "R2 image scanned", 0, 0);
    end else begin
      for (int r = 20; r < 32; r++)
        check(rf[r] == expRf[r], "R4 restored register", rf[r], expRf[r]);
      check(jumpValid == (v.jr != 0), "R5 jumpValid", 32'(jumpValid), 32'(v.jr != 0));
      if (v.jr != 0)
        check(jumpTarget == expRf[v.jr], "R5 jumpTarget", jumpTarget, expRf[v.jr]);
    end
    @(negedge clk);
    check(!done && !busy, "R8 done single pulse", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    presetRf();
    repeat (3) @(negedge clk);
    check(!busy && !done && !memReq && !rfWrEn, "R10 reset outputs",
          {28'd0, busy, done, memReq, rfWrEn}, 32'd0);
    check(spOut == 32'd0, "R10 reset sp", spOut, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !memReq, "R10 idle after reset", {30'd0, busy, memReq}, 32'd0);

    // table walk: R1 masks, R2/R3 saves, R4/R5 restores, R6 empty, R7 stalls
    for (int t = 0; t < 8; t++) doVector(VECS[t], 1'b0);

    // R9: second start during a stalled save is ignored
    doVector(VECS[1], 1'b1);
    // R9: second start during a restore is ignored
    doVector(VECS[4], 1'b1);

    // R1: high bit alone restores register 31 only
    doVector('{1'b1, 1'b1, 11'h000, 5'd1, 5'd31, 32'h020, 1'b1}, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule